// File: doc/BRIEF.md
# Synchronous Serial Port Engine

This block moves 8-bit frames over a four-wire synchronous serial link (SPI). It can act as the clock-owning master or as a slave that follows an external clock and select. A byte-wide control word picks the role, clock polarity, sampling phase and bit order. It also enables the engine, the select output and the two interrupt sources. Software reaches the block through a small synchronous register port that has three addresses: control, status and data.

In master mode, a byte written to the data address starts a frame. The engine generates the serial clock from the system clock with a fixed divider. It drives the select low when select output is enabled, and it shifts the byte out while it captures the reply. In slave mode, a falling select input starts a frame. The engine follows the clock input and shifts the pending byte out on the slave output. When 16 clock edges are complete, the transfer-complete flag is raised. Some control writes abort a frame that is in progress. Disabling the engine clears its status.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, control reads 0x04, status reads 0x20, sckOut is 0, ssOut is 1 and irq is 0.
- R2: The control word is readable and writable at any time at address 0. Its bits, from bit 7 down to bit 0, are: interrupt enable, engine enable, transmit-empty interrupt enable, master select, clock polarity (CPOL), clock phase (CPHA), select output enable and LSB-first.
- R3: While the engine enable bit is 0, the engine stays idle and data writes are ignored. Transfer-complete and mode-fault read 0, and transmit-empty reads 1. In the status word at address 1, transfer-complete is bit 7, transmit-empty is bit 5 and mode-fault is bit 4.
- R4: irq is high when interrupt enable is set and either transfer-complete or mode-fault is set. irq is also high when transmit-empty interrupt enable and transmit-empty are both set.
- R5: In master mode, sckOut idles at CPOL. Each frame has 16 sckOut edges, spaced CLK_DIV system clocks apart. When select output is enabled, ssOut stays low for the whole frame. Transfer-complete becomes visible 16*CLK_DIV+2 clocks after the clock edge that accepts the data write.
- R6: With CPHA=0, the first bit is on the data output before edge 1, data is sampled on odd edges and the next bit is driven on even edges. With CPHA=1, bits are driven on odd edges and sampled on even edges.
- R7: With LSB-first=1, bit 0 goes first. With LSB-first=0, bit 7 goes first. The same order applies to sent and received data.
- R8: A control write that changes master select, in either direction, ends any frame at once. Select goes high, the clock returns to idle and no transfer-complete follows.
- R9: In master mode, a control write that changes CPOL or CPHA ends the frame in the same way.
- R10: A data write is accepted only while transmit-empty is 1, and it clears transmit-empty. Transmit-empty is set again when the engine takes the byte. Reading address 2 returns the last received byte and clears transfer-complete.
- R11: In slave mode, a falling ssIn loads the pending byte. The frame follows sckIn with the same phase and order rules and drives misoOut. It samples mosiIn, and transfer-complete is raised after the 16th sckIn edge.
- R12: In master mode with select output disabled, a low ssIn sets mode-fault and holds the engine idle. The next control write clears mode-fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears transfer-complete on data) |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr, combinational |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from an external master |
| sckOut | output | 1 | Serial clock driven in master mode |
| ssIn | input | 1 | Select input (slave frame / master fault) |
| ssOut | output | 1 | Select output, active low |
| mosiIn | input | 1 | Slave data input |
| mosiOut | output | 1 | Master data output |
| misoIn | input | 1 | Master data input |
| misoOut | output | 1 | Slave data output |

## Verification
In master mode, transfer-complete is due exactly 16*CLK_DIV+2 clocks after the data write. The bench counts falling clock edges from that write to irq and compares the count with the formula. After an aborting control write, the bench waits two clocks before it checks the idle clock and the high select, since the clock register returns to the new polarity one cycle after the abort. Slave inputs pass through two-stage synchronizers, so they are seen three clocks late. The bench therefore spaces slave clock edges eight clocks apart, samples misoOut just before each toggle and reads the flags well after the last edge. Mode-fault follows ssIn through the same synchronizer delay.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control word, bit 7 first
  typedef struct packed {
    logic intEn;
    logic spe;
    logic txIntEn;
    logic master;
    logic cpol;
    logic cpha;
    logic ssoe;
    logic lsbFirst;
  } ssp_cfg_t;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic abort;
    logic txReady;
    logic runMaster;
    logic runSlave;
    logic cpol;
    logic cpha;
    logic lsbFirst;
    logic ssDrive;
  } ssp_strobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output ssp_strobe_t       strb,
  output logic [DATA_W-1:0] txData,
  input  logic              takeTx,
  input  logic              done,
  input  logic              ssLow,
  input  logic [DATA_W-1:0] rxByte
);
  ssp_cfg_t cfg, cfgNew;
  logic spif, sptef, modf, txFull;
  logic ctrlWr, dataWr, dataRd, abortWr, modeFault;

  assign cfgNew = ssp_cfg_t'(regWdata[7:0]);
  assign ctrlWr = regWr && regAddr == ADDR_CTRL;
  assign dataWr = regWr && regAddr == ADDR_DATA;
  assign dataRd = regRd && regAddr == ADDR_DATA;

  // role change, disable, or master clock-format change ends a frame
  assign abortWr = ctrlWr && (cfgNew.master != cfg.master || !cfgNew.spe ||
                   (cfg.master && (cfgNew.cpol != cfg.cpol || cfgNew.cpha != cfg.cpha)));
  assign modeFault = cfg.spe && cfg.master && !cfg.ssoe && ssLow;

  always_comb begin
    strb.abort     = !cfg.spe || abortWr || modeFault;
    strb.txReady   = txFull;
    strb.runMaster = cfg.spe && cfg.master;
    strb.runSlave  = cfg.spe && !cfg.master;
    strb.cpol      = cfg.cpol;
    strb.cpha      = cfg.cpha;
    strb.lsbFirst  = cfg.lsbFirst;
    strb.ssDrive   = cfg.spe && cfg.master && cfg.ssoe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= ssp_cfg_t'(8'h04);
      spif   <= 1'b0;
      sptef  <= 1'b1;
      modf   <= 1'b0;
      txFull <= 1'b0;
      txData <= '0;
    end else begin
      if (ctrlWr) cfg <= cfgNew;
      if (!cfg.spe) begin
        spif   <= 1'b0;
        modf   <= 1'b0;
        sptef  <= 1'b1;
        txFull <= 1'b0;
      end else begin
        if (done) spif <= 1'b1;
        else if (dataRd) spif <= 1'b0;
        if (modeFault) modf <= 1'b1;
        else if (ctrlWr) modf <= 1'b0;
        if (takeTx) begin
          txFull <= 1'b0;
          sptef  <= 1'b1;
        end else if (dataWr && sptef) begin
          txData <= regWdata;
          txFull <= 1'b1;
          sptef  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdata = DATA_W'(cfg);
      ADDR_STAT: regRdata = DATA_W'({spif, 1'b0, sptef, modf, 4'b0000});
      ADDR_DATA: regRdata = rxByte;
      default:   regRdata = '0;
    endcase
  end

  assign irq = (cfg.intEn && (spif || modf)) || (cfg.txIntEn && sptef);

  // R3: a disabled engine holds its flags at their cleared values
  p_off_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.spe |=> (!spif && !modf && sptef));
  // R5: transfer-complete rises only after the engine reports a finished frame
  p_spif_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spif) |-> $past(done));
  // R10: the engine takes a byte only when one is waiting
  p_take_full_r10: assert property (@(posedge clk) disable iff (!rstN)
    takeTx |-> txFull);
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssp_strobe_t       strb,
  input  logic [DATA_W-1:0] txData,
  output logic              takeTx,
  output logic              done,
  output logic [DATA_W-1:0] rxByte,
  output logic              ssLow,
  input  logic              sckIn,
  input  logic              ssIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              sckOut,
  output logic              mosiOut,
  output logic              misoOut,
  output logic              ssOut
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES + 1);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int IW    = $clog2(DATA_W);

  logic [1:0] sckS, ssS, mosiS;
  logic sckD, ssD;
  logic active, sckReg;
  logic [CW-1:0] edgeCnt, nextCnt, rawIdx;
  logic [DIV_W-1:0] divCnt;
  logic [DATA_W-1:0] txReg, rxReg, rxShift;
  logic [IW-1:0] idx;
  logic slaveEdge, ssFall, slaveQuit, start, divEnd, tick, sampleNow, inBit, outBit;

  // two-stage synchronizers for the slave-side pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS  <= 2'b00;
      ssS   <= 2'b11;
      mosiS <= 2'b00;
      sckD  <= 1'b0;
      ssD   <= 1'b1;
    end else begin
      sckS  <= {sckS[0], sckIn};
      ssS   <= {ssS[0], ssIn};
      mosiS <= {mosiS[0], mosiIn};
      sckD  <= sckS[1];
      ssD   <= ssS[1];
    end
  end

  assign ssLow     = !ssS[1];
  assign slaveEdge = sckS[1] ^ sckD;
  assign ssFall    = ssD && !ssS[1];
  assign slaveQuit = strb.runSlave && active && !ssLow;
  assign start     = !active && !strb.abort &&
                     (strb.runMaster ? strb.txReady : (strb.runSlave && ssFall));
  assign takeTx    = start && strb.txReady;
  assign divEnd    = divCnt == DIV_W'(CLK_DIV - 1);
  assign tick      = active && edgeCnt != CW'(EDGES) &&
                     (strb.runMaster ? divEnd : (strb.runSlave && slaveEdge));
  assign nextCnt   = edgeCnt + 1'b1;
  assign sampleNow = tick && (nextCnt[0] ^ strb.cpha);
  assign inBit     = strb.runMaster ? misoIn : mosiS[1];
  assign done      = active && edgeCnt == CW'(EDGES);
  assign rxShift   = strb.lsbFirst ? {inBit, rxReg[DATA_W-1:1]} : {rxReg[DATA_W-2:0], inBit};

  // bit slot currently on the wire, derived from the edge count
  always_comb begin
    if (strb.cpha) rawIdx = (edgeCnt == '0) ? '0 : ((edgeCnt - 1'b1) >> 1);
    else           rawIdx = edgeCnt >> 1;
    if (rawIdx > CW'(DATA_W - 1)) rawIdx = CW'(DATA_W - 1);
    idx = IW'(rawIdx);
  end
  assign outBit = strb.lsbFirst ? txReg[idx] : txReg[IW'(DATA_W - 1) - idx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      edgeCnt <= '0;
      divCnt  <= '0;
      sckReg  <= 1'b0;
      txReg   <= '0;
      rxReg   <= '0;
      rxByte  <= '0;
    end else if (strb.abort || slaveQuit) begin
      active  <= 1'b0;
      edgeCnt <= '0;
      divCnt  <= '0;
      sckReg  <= strb.cpol;
    end else if (start) begin
      active  <= 1'b1;
      edgeCnt <= '0;
      divCnt  <= '0;
      txReg   <= takeTx ? txData : '0;
      sckReg  <= strb.cpol;
    end else if (done) begin
      active  <= 1'b0;
      rxByte  <= rxReg;
      sckReg  <= strb.cpol;
    end else if (active) begin
      if (strb.runMaster) divCnt <= divEnd ? '0 : divCnt + 1'b1;
      if (tick) begin
        edgeCnt <= nextCnt;
        if (strb.runMaster) sckReg <= ~sckReg;
        if (sampleNow) rxReg <= rxShift;
      end
    end else begin
      sckReg <= strb.cpol;
    end
  end

  assign sckOut  = strb.runMaster ? sckReg : strb.cpol;
  assign mosiOut = strb.runMaster && active && outBit;
  assign misoOut = strb.runSlave && active && outBit;
  assign ssOut   = !(strb.ssDrive && active);

  // R5: the edge counter never passes the frame length
  p_edge_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= CW'(EDGES));
  // R5: completion is a single-cycle event
  p_done_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: an abort strobe always leaves the engine idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> !active);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  input  logic              ssIn,
  output logic              ssOut,
  input  logic              mosiIn,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic              misoOut
);
  ssp_strobe_t strb;
  logic [DATA_W-1:0] txData, rxByte;
  logic takeTx, done, ssLow;

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .strb(strb),
    .txData(txData), .takeTx(takeTx), .done(done), .ssLow(ssLow), .rxByte(rxByte)
  );

  ssp_datapath #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .takeTx(takeTx),
    .done(done), .rxByte(rxByte), .ssLow(ssLow), .sckIn(sckIn), .ssIn(ssIn),
    .mosiIn(mosiIn), .misoIn(misoIn), .sckOut(sckOut), .mosiOut(mosiOut),
    .misoOut(misoOut), .ssOut(ssOut)
  );
endmodule

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
  localparam int DIV = 2;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic irq, sckOut, ssOut, mosiOut, misoOut;
  logic sckIn = 1'b0, ssIn = 1'b1, mosiIn = 1'b0, misoIn = 1'b0;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_serial_port #(.DATA_W(8), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sckIn(sckIn), .sckOut(sckOut),
    .ssIn(ssIn), .ssOut(ssOut), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .misoIn(misoIn), .misoOut(misoOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  function automatic int pos(input logic lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  // bench model of a remote slave answering the master
  bit modelOn = 0;
  int mEdge, mSamp, mDrv;
  logic prevSck, mCpha, mLsb, ssBad;
  logic [7:0] mCap, mRsp;
  always @(negedge clk) begin
    if (modelOn && sckOut !== prevSck) begin
      prevSck = sckOut;
      mEdge++;
      if (ssOut) ssBad = 1'b1;
      if (((mEdge % 2) == 1) != mCpha) begin
        if (mSamp < 8) mCap[pos(mLsb, mSamp)] = mosiOut;
        mSamp++;
      end else begin
        if (mDrv < 8) misoIn = mRsp[pos(mLsb, mDrv)];
        mDrv++;
      end
    end
  end

  task automatic masterFrame(input logic cpol, input logic cpha, input logic lsb,
                             input logic [7:0] tx, input logic [7:0] rsp);
    logic [7:0] v;
    int cnt;
    wr(2'd0, {1'b1, 1'b1, 1'b0, 1'b1, cpol, cpha, 1'b1, lsb});
    @(negedge clk);
    check(sckOut == cpol, "R5 idle clock level", sckOut, cpol);
    mCpha = cpha; mLsb = lsb; mRsp = rsp; mEdge = 0; mSamp = 0;
    mDrv = cpha ? 0 : 1; mCap = '0; ssBad = 1'b0; prevSck = sckOut;
    misoIn = rsp[pos(lsb, 0)];
    modelOn = 1;
    wr(2'd2, tx);
    cnt = 0;
    while (!irq && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    modelOn = 0;
    check(cnt == 16 * DIV + 2, "R5 completion latency", cnt, 16 * DIV + 2);
    check(mEdge == 16, "R5 clock edge count", mEdge, 16);
    check(!ssBad, "R5 select low during frame", ssBad, 0);
    check(sckOut == cpol, "R5 clock back to idle", sckOut, cpol);
    check(mCap == tx, "R6 R7 master bits sent", mCap, tx);
    rd(2'd2, v);
    check(v == rsp, "R6 R7 master bits received", v, rsp);
    check(!irq, "R10 data read clears complete", irq, 0);
  endtask

  task automatic slaveFrame(input logic cpol, input logic cpha, input logic lsb,
                            input logic [7:0] tx, input logic [7:0] rsp, input bit doWrite);
    logic [7:0] v, cap;
    int k;
    sckIn = cpol;
    wr(2'd0, {1'b1, 1'b1, 1'b0, 1'b0, cpol, cpha, 1'b0, lsb});
    if (doWrite) wr(2'd2, tx);
    repeat (4) @(negedge clk);
    cap = '0; k = 0;
    ssIn = 1'b0;
    mosiIn = rsp[pos(lsb, 0)];
    repeat (8) @(negedge clk);
    for (int e = 1; e <= 16; e++) begin
      if (((e % 2) == 1) != cpha) begin
        cap[pos(lsb, k)] = misoOut;
        k++;
      end
      sckIn = ~sckIn;
      if (((e % 2) == 1) == cpha) begin
        if (cpha && ((e - 1) / 2) < 8) mosiIn = rsp[pos(lsb, (e - 1) / 2)];
        if (!cpha && (e / 2) < 8) mosiIn = rsp[pos(lsb, e / 2)];
      end
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(irq, "R11 slave complete raised", irq, 1);
    check(cap == tx, "R11 R6 R7 slave bits sent", cap, tx);
    rd(2'd2, v);
    check(v == rsp, "R11 R6 R7 slave bits received", v, rsp);
    ssIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] txs [4];
    logic [7:0] rsps [4];
    txs  = '{8'h96, 8'h01, 8'hFF, 8'hD2};
    rsps = '{8'h3C, 8'h80, 8'h00, 8'h4B};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check(v == 8'h04, "R1 control reset", v, 8'h04);
    rd(2'd1, v); check(v == 8'h20, "R1 status reset", v, 8'h20);
    check(sckOut == 1'b0 && ssOut == 1'b1 && irq == 1'b0, "R1 pin reset",
          {sckOut, ssOut, irq}, 3'b010);

    // R2 read-back of control bits
    wr(2'd0, 8'hA5); rd(2'd0, v); check(v == 8'hA5, "R2 control readback", v, 8'hA5);
    wr(2'd0, 8'h5A); rd(2'd0, v); check(v == 8'h5A, "R2 control readback", v, 8'h5A);
    check(irq == 1'b0, "R4 no source while disabled", irq, 0);
    wr(2'd0, 8'h00);

    // R6 R7 R5 master sweep over formats, orders and bytes
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 4; b++)
          masterFrame(m[1], m[0], l[0], txs[b], rsps[b]);

    // R11 slave sweep
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 2; b++)
          slaveFrame(m[1], m[0], l[0], rsps[b + 2], txs[b + 1], 1'b1);

    // R4 R10 transmit-empty interrupt, and a write while full is ignored
    wr(2'd0, 8'b0110_0000);
    @(negedge clk);
    check(irq == 1'b1, "R4 empty buffer interrupt", irq, 1);
    wr(2'd2, 8'h5C);
    check(irq == 1'b0, "R4 R10 write clears empty", irq, 0);
    wr(2'd2, 8'hE1);
    slaveFrame(1'b0, 1'b0, 1'b0, 8'h5C, 8'h77, 1'b0);

    // R9 polarity change mid-frame aborts
    wr(2'd0, 8'b1101_0010);
    @(negedge clk);
    wr(2'd2, 8'hC3);
    repeat (10) @(negedge clk);
    check(ssOut == 1'b0, "R5 select low mid-frame", ssOut, 0);
    wr(2'd0, 8'b1101_1010);
    @(negedge clk);
    check(sckOut == 1'b1 && ssOut == 1'b1, "R9 abort to idle", {sckOut, ssOut}, 2'b11);
    repeat (60) @(negedge clk);
    check(irq == 1'b0, "R9 no completion after abort", irq, 0);

    // R8 role change mid-frame aborts
    wr(2'd0, 8'b1101_0010);
    @(negedge clk);
    wr(2'd2, 8'h3A);
    repeat (12) @(negedge clk);
    wr(2'd0, 8'b1100_0010);
    @(negedge clk);
    check(sckOut == 1'b0 && ssOut == 1'b1, "R8 abort to idle", {sckOut, ssOut}, 2'b01);
    repeat (60) @(negedge clk);
    rd(2'd1, v);
    check(v[7] == 1'b0, "R8 no completion after abort", v, 8'h20);

    // R3 disable clears flags and ignores data
    masterFrame(1'b0, 1'b0, 1'b0, 8'h11, 8'h22);
    wr(2'd2, 8'h44);
    repeat (40) @(negedge clk);
    check(irq == 1'b1, "R3 complete set before disable", irq, 1);
    wr(2'd0, 8'b1001_0010);
    @(negedge clk);
    rd(2'd1, v);
    check(v == 8'h20, "R3 flags cleared by disable", v, 8'h20);
    wr(2'd2, 8'h99);
    rd(2'd1, v);
    check(v == 8'h20, "R3 data write ignored", v, 8'h20);
    wr(2'd0, 8'b1101_0010);
    repeat (20) @(negedge clk);
    check(ssOut == 1'b1 && irq == 1'b0, "R3 no frame from ignored write", {ssOut, irq}, 2'b10);

    // R12 mode fault
    wr(2'd0, 8'b1101_0000);
    ssIn = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, v);
    check(v[4] == 1'b1, "R12 mode fault set", v, 8'h30);
    check(irq == 1'b1, "R12 R4 mode fault interrupt", irq, 1);
    ssIn = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'b1101_0000);
    rd(2'd1, v);
    check(v[4] == 1'b0, "R12 mode fault cleared by control write", v, 8'h20);
    check(irq == 1'b0, "R12 interrupt released", irq, 0);

    report();
  end
endmodule